// File: doc/BRIEF.md
# Variable-Precision FIR Filter Engine

This block is a 20-tap FIR filter that computes one output word for each input sample. Software picks the word length at run time from three settings: 16, 24 or 48 bits. The engine has a single multiply-accumulate path and visits the taps one after another. In the 16-bit setting each product comes from a radix-4 Booth array in one cycle. In the two wider settings a shift-add multiplier retires one multiplier bit per cycle.

The storage is split into two 24-bit lanes. The lower lane holds the 24 least significant bits of every sample. The upper lane holds the 24 most significant bits, and it is written only in the 48-bit setting, so in the narrower settings it keeps its contents and does not toggle. The serial adder is likewise built from a lower 24-bit slice and an upper slice joined by a carry.

Samples enter on a valid/ready stream, and results leave as a one-cycle valid pulse. Coefficients are loaded through a separate write port, and all 20 of them must be loaded before the first sample is sent.

Top module: `vpfir_engine`

## Requirements
- R1: After reset `m_valid` is 0, `m_data` is 0, `s_ready` is 1 (with `mode` held at 00), and every stored past sample is zero.
- R2: For each accepted sample the result is y = sum over k=0..19 of c[k]·x[n-k], computed at full precision in two's complement, where samples that precede the first one accepted count as zero. The output word is bits [2W-2 : W-1] of that sum, sign-extended from W bits to 48 bits, where W is the selected width.
- R3: The `mode` encoding is 00 = 16 bits (only `s_data[15:0]` and `coef_data[15:0]` are used), 01 = 24 bits (bits [23:0] are used) and 10 = 48 bits (all 48 bits are used). The code 11 behaves like 00. Unused upper bits have no effect on the result.
- R4: `s_ready` falls in the cycle after a sample is accepted and stays low until the result appears. `m_valid` is high for exactly one cycle per accepted sample, and `m_data` changes only together with `m_valid`.
- R5: From the accepting clock edge to the edge that raises `m_valid`, the engine takes at most 24 cycles in the 16-bit setting, between 480 and 544 cycles in the 24-bit setting, and between 960 and 1024 cycles in the 48-bit setting.
- R6: A change of `mode` while the engine is idle holds `s_ready` low for at least one cycle and clears the sample history. The first result after the change therefore depends only on the new sample and c[0].
- R7: A coefficient write to an address of 20 or higher is ignored. A write to a valid address takes effect from the next accepted sample.
- R8: The most negative sample multiplied by the most negative coefficient is computed exactly in every setting, wrapping as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Word-length select (00/11 = 16, 01 = 24, 10 = 48) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Tap index for the coefficient write |
| coef_data | input | 48 | Coefficient value (two's complement) |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Engine can accept a sample |
| s_data | input | 48 | Input sample (two's complement) |
| m_valid | output | 1 | One-cycle result strobe |
| m_data | output | 48 | Result, sign-extended to 48 bits |

## Verification
The bench targets the most negative operands in each setting. A Booth digit decoder that mishandles the sign, or a serial step that fails to subtract on the final multiplier bit, gives the wrong sign or a result that is off by a power of two. It also fills the upper input bits with random values in the narrow settings, where a missing mask would leak those bits into the sum. Further checks cover a mode change followed by a single sample, where a history that was not cleared shows up as extra terms, and out-of-range coefficient addresses, where a wrapping address decoder would corrupt a low tap.

// File: rtl/vpfir_pkg.sv
package vpfir_pkg;

  typedef enum logic [1:0] {
    WSEL_16 = 2'd0,
    WSEL_24 = 2'd1,
    WSEL_48 = 2'd2
  } wsel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAP  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } fsm_e;

  // 01 -> 24-bit, 10 -> 48-bit, 00 and 11 -> 16-bit
  function automatic wsel_e width_sel(input logic [1:0] m);
    case (m)
      2'b01:   return WSEL_24;
      2'b10:   return WSEL_48;
      default: return WSEL_16;
    endcase
  endfunction

endpackage

// File: rtl/vpfir_booth_mul.sv
module vpfir_booth_mul #(
  parameter int W = 16
) (
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic signed [2*W-1:0] p
);
  localparam int ND = W / 2;
  localparam int PW = 2 * W;

  logic [W:0]           b_ext;
  logic signed [PW-1:0] a_one;
  logic signed [PW-1:0] a_two;
  logic signed [PW-1:0] pp [ND];

  assign b_ext = {b, 1'b0};
  assign a_one = {{W{a[W-1]}}, a};
  assign a_two = a_one <<< 1;

  generate
    for (genvar i = 0; i < ND; i++) begin : g_digit
      logic [2:0]           trip;
      logic signed [PW-1:0] sel;
      assign trip = b_ext[2*i +: 3];
      always_comb begin
        case (trip)
          3'b001, 3'b010: sel = a_one;
          3'b011:         sel = a_two;
          3'b100:         sel = -a_two;
          3'b101, 3'b110: sel = -a_one;
          default:        sel = '0;
        endcase
      end
      assign pp[i] = sel <<< (2 * i);
    end
  endgenerate

  always_comb begin
    p = '0;
    for (int i = 0; i < ND; i++) p = p + pp[i];
  end
endmodule

// File: rtl/vpfir_serial_mul.sv
module vpfir_serial_mul #(
  parameter int LANE_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  wide,
  input  logic [2*LANE_W-1:0]   mcand,
  input  logic [2*LANE_W-1:0]   mplier,
  output logic                  busy,
  output logic                  done,
  output logic [4*LANE_W-1:0]   product
);
  localparam int DW = 2 * LANE_W;
  localparam int PW = DW + 2;
  localparam int HW = PW - LANE_W;
  localparam int CW = $clog2(DW + 1);

  logic [PW-1:0]   part_q;
  logic [DW-1:0]   low_q;
  logic [DW-1:0]   mc_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   last_q;
  logic            wide_q;

  logic [PW-1:0]   mc_ext;
  logic [PW-1:0]   op;
  logic            cin;
  logic            is_last;
  logic [LANE_W:0] lo_sum;
  logic [HW-1:0]   hi_sum;
  logic [PW-1:0]   sum;
  logic signed [PW+DW-1:0] full;
  logic signed [PW+DW-1:0] full_sh;

  assign mc_ext  = {{2{mc_q[DW-1]}}, mc_q};
  assign is_last = (cnt_q == last_q);

  // final multiplier bit carries negative weight: subtract there
  always_comb begin
    if (!low_q[0]) begin
      op  = '0;
      cin = 1'b0;
    end else if (is_last) begin
      op  = ~mc_ext;
      cin = 1'b1;
    end else begin
      op  = mc_ext;
      cin = 1'b0;
    end
  end

  // two adder slices joined by a carry
  assign lo_sum = {1'b0, part_q[LANE_W-1:0]} + {1'b0, op[LANE_W-1:0]}
                + {{LANE_W{1'b0}}, cin};
  assign hi_sum = part_q[PW-1:LANE_W] + op[PW-1:LANE_W]
                + {{(HW-1){1'b0}}, lo_sum[LANE_W]};
  assign sum    = {hi_sum, lo_sum[LANE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= '0;
      low_q  <= '0;
      mc_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      wide_q <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        part_q <= '0;
        low_q  <= mplier;
        mc_q   <= mcand;
        cnt_q  <= '0;
        last_q <= wide ? CW'(DW - 1) : CW'(LANE_W - 1);
        wide_q <= wide;
        busy   <= 1'b1;
      end else if (busy) begin
        part_q <= {sum[PW-1], sum[PW-1:1]};
        low_q  <= {sum[0], low_q[DW-1:1]};
        cnt_q  <= cnt_q + CW'(1);
        if (is_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign full    = $signed({part_q, low_q});
  assign full_sh = wide_q ? full : (full >>> LANE_W);
  assign product = full_sh[4*LANE_W-1:0];
endmodule

// File: rtl/vpfir_delay_line.sv
module vpfir_delay_line #(
  parameter int NTAPS  = 20,
  parameter int LANE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       we,
  input  logic                       wide,
  input  logic [2*LANE_W-1:0]        din,
  input  logic [$clog2(NTAPS)-1:0]   k,
  output logic [2*LANE_W-1:0]        dout
);
  localparam int IW = $clog2(NTAPS);
  localparam int PW = IW + 1;

  logic [IW-1:0] wp_q;
  logic [IW-1:0] head_q;
  logic [PW-1:0] rd_sum;
  logic [IW-1:0] rd_idx;

  always_comb begin
    if ({1'b0, head_q} >= {1'b0, k})
      rd_sum = {1'b0, head_q} - {1'b0, k};
    else
      rd_sum = {1'b0, head_q} + PW'(NTAPS) - {1'b0, k};
    rd_idx = rd_sum[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q   <= '0;
      head_q <= '0;
    end else if (we) begin
      head_q <= wp_q;
      wp_q   <= (wp_q == IW'(NTAPS - 1)) ? '0 : wp_q + IW'(1);
    end
  end

  generate
    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [LANE_W-1:0] mem [NTAPS];
      logic              lane_en;
      if (l == 0) begin : g_lo
        assign lane_en = 1'b1;
      end else begin : g_hi
        assign lane_en = wide;
      end
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          for (int i = 0; i < NTAPS; i++) mem[i] <= '0;
        end else if (we && lane_en) begin
          mem[wp_q] <= din[l*LANE_W +: LANE_W];
        end
      end
      assign dout[l*LANE_W +: LANE_W] = mem[rd_idx];
    end
  endgenerate
endmodule

// File: rtl/vpfir_engine.sv
module vpfir_engine
  import vpfir_pkg::*;
#(
  parameter int NTAPS    = 20,
  parameter int LANE_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                mode,
  input  logic                      coef_we,
  input  logic [$clog2(NTAPS)-1:0]  coef_addr,
  input  logic [2*LANE_W-1:0]       coef_data,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [2*LANE_W-1:0]       s_data,
  output logic                      m_valid,
  output logic [2*LANE_W-1:0]       m_data
);
  localparam int DATA_W = 2 * LANE_W;
  localparam int ADDR_W = $clog2(NTAPS);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + $clog2(NTAPS) + 1;

  fsm_e                     state_q;
  logic [1:0]               mode_q;
  logic [ADDR_W-1:0]        tap_q;
  logic signed [ACC_W-1:0]  acc_q;
  wsel_e                    wsel;
  logic                     is48;
  logic                     last_tap;
  logic                     accept;
  logic                     mode_chg;

  logic [LANE_W-1:0]        c_lo [NTAPS];
  logic [LANE_W-1:0]        c_hi [NTAPS];
  logic [DATA_W-1:0]        coef_cur;
  logic [DATA_W-1:0]        samp;

  logic signed [2*NARROW_W-1:0] booth_p;
  logic signed [ACC_W-1:0]      booth_ext;
  logic [DATA_W-1:0]            ser_a;
  logic [DATA_W-1:0]            ser_b;
  logic                         ser_start;
  logic                         ser_busy;
  logic                         ser_done;
  logic [PROD_W-1:0]            ser_p;
  logic signed [ACC_W-1:0]      ser_ext;
  logic [DATA_W-1:0]            out_word;

  assign wsel     = width_sel(mode_q);
  assign is48     = (wsel == WSEL_48);
  assign last_tap = (tap_q == ADDR_W'(NTAPS - 1));
  assign mode_chg = (state_q == ST_IDLE) && (mode != mode_q);
  assign s_ready  = (state_q == ST_IDLE) && (mode == mode_q);
  assign accept   = s_valid && s_ready;

  // coefficient store: both lanes always loaded, no reset (RAM style)
  always_ff @(posedge clk) begin
    if (coef_we && (coef_addr < ADDR_W'(NTAPS))) begin
      c_lo[coef_addr] <= coef_data[LANE_W-1:0];
      c_hi[coef_addr] <= coef_data[DATA_W-1:LANE_W];
    end
  end
  assign coef_cur = {c_hi[tap_q], c_lo[tap_q]};

  vpfir_delay_line #(.NTAPS(NTAPS), .LANE_W(LANE_W)) u_dline (
    .clk  (clk),
    .rst  (rst),
    .clr  (mode_chg),
    .we   (accept),
    .wide (is48),
    .din  (s_data),
    .k    (tap_q),
    .dout (samp)
  );

  vpfir_booth_mul #(.W(NARROW_W)) u_booth (
    .a (samp[NARROW_W-1:0]),
    .b (coef_cur[NARROW_W-1:0]),
    .p (booth_p)
  );
  assign booth_ext = booth_p;

  assign ser_a     = is48 ? samp : {{LANE_W{samp[LANE_W-1]}}, samp[LANE_W-1:0]};
  assign ser_b     = is48 ? coef_cur
                          : {{LANE_W{coef_cur[LANE_W-1]}}, coef_cur[LANE_W-1:0]};
  assign ser_start = (state_q == ST_TAP) && (wsel != WSEL_16);

  vpfir_serial_mul #(.LANE_W(LANE_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .start   (ser_start),
    .wide    (is48),
    .mcand   (ser_a),
    .mplier  (ser_b),
    .busy    (ser_busy),
    .done    (ser_done),
    .product (ser_p)
  );
  assign ser_ext = $signed(ser_p);

  always_comb begin
    case (wsel)
      WSEL_24: out_word = {{(DATA_W-LANE_W){acc_q[2*LANE_W-2]}},
                           acc_q[LANE_W-1 +: LANE_W]};
      WSEL_48: out_word = acc_q[DATA_W-1 +: DATA_W];
      default: out_word = {{(DATA_W-NARROW_W){acc_q[2*NARROW_W-2]}},
                           acc_q[NARROW_W-1 +: NARROW_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= 2'b00;
      tap_q   <= '0;
      acc_q   <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (mode_chg) begin
            mode_q <= mode;
            acc_q  <= '0;
          end else if (accept) begin
            tap_q   <= '0;
            acc_q   <= '0;
            state_q <= ST_TAP;
          end
        end
        ST_TAP: begin
          if (wsel == WSEL_16) begin
            acc_q <= acc_q + booth_ext;
            if (last_tap) state_q <= ST_OUT;
            else          tap_q   <= tap_q + ADDR_W'(1);
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ser_done) begin
            acc_q <= acc_q + ser_ext;
            if (last_tap) begin
              state_q <= ST_OUT;
            end else begin
              tap_q   <= tap_q + ADDR_W'(1);
              state_q <= ST_TAP;
            end
          end
        end
        default: begin
          m_valid <= 1'b1;
          m_data  <= out_word;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/vpfir_engine_chk.sv
module vpfir_engine_chk #(
  parameter int DATA_W   = 48,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic [DATA_W-1:0] m_data,
  input logic [1:0]        mode,
  input logic [1:0]        mode_q,
  input logic              ser_busy,
  input logic              ser_done
);
  localparam int EXT_N = DATA_W - NARROW_W + 1;

  // R4: ready drops after a handshake
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R4: result strobe lasts one cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    m_valid |=> !m_valid);

  // R4: output word only moves with the strobe
  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_data) |-> m_valid);

  // R2: narrow results are sign-extended
  p_narrow_sext_r2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && (mode_q == 2'b00 || mode_q == 2'b11)) |->
      ($countones(m_data[DATA_W-1:NARROW_W-1]) == 0 ||
       $countones(m_data[DATA_W-1:NARROW_W-1]) == EXT_N));

  // R6: no acceptance while a new mode is pending
  p_mode_block_r6: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |-> !s_ready);

  // R5: serial multiplier finishes only after running
  p_ser_done_r5: assert property (@(posedge clk) disable iff (rst)
    ser_done |-> ($past(ser_busy) && !ser_busy));
endmodule

bind vpfir_engine vpfir_engine_chk #(.DATA_W(2*LANE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_data   (m_data),
  .mode     (mode),
  .mode_q   (mode_q),
  .ser_busy (ser_busy),
  .ser_done (ser_done)
);

// File: tb/test_vpfir_engine.sv
module test_vpfir_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 20;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        coef_we;
  logic [4:0]  coef_addr;
  logic [47:0] coef_data;
  logic        s_valid;
  logic        s_ready;
  logic [47:0] s_data;
  logic        m_valid;
  logic [47:0] m_data;

  int total = 0;
  int bad   = 0;
  logic [47:0] coefs [NT];
  logic [47:0] hist  [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpfir_engine i_vpfir_engine (
    .clk(clk), .rst(rst), .mode(mode), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid), .m_data(m_data)
  );

  function automatic int wfor(input logic [1:0] m);
    if (m == 2'b01) return 24;
    if (m == 2'b10) return 48;
    return 16;
  endfunction

  function automatic logic signed [47:0] sx(input logic [47:0] v, input int w);
    logic [47:0] t;
    t = v << (48 - w);
    return $signed(t) >>> (48 - w);
  endfunction

  function automatic logic [47:0] ref_y(input int w);
    logic signed [101:0] acc, ea, eb;
    acc = '0;
    for (int k = 0; k < NT; k++) begin
      ea = sx(hist[k], w);
      eb = sx(coefs[k], w);
      acc = acc + ea * eb;
    end
    acc = acc >>> (w - 1);
    return sx(acc[47:0], w);
  endfunction

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_coef(input int addr, input logic [47:0] val);
    @(negedge clk);
    coef_we = 1'b1;
    coef_addr = 5'(addr);
    coef_data = val;
    @(negedge clk);
    coef_we = 1'b0;
    if (addr < NT) coefs[addr] = val;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    #1;
    check("R6 ready low on mode change", {47'd0, s_ready}, 48'd0);
    for (int k = 0; k < NT; k++) hist[k] = '0;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
  endtask

  task automatic send(input string tag, input logic [47:0] x);
    int n;
    int w;
    logic ready_bad;
    w = wfor(mode);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = x;
    while (!s_ready) @(negedge clk);
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    n = 0;
    ready_bad = 1'b0;
    while (!m_valid && n < 2000) begin
      if (s_ready) ready_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    check("R4 ready low while busy", {47'd0, ready_bad}, 48'd0);
    if (w == 16)
      check("R5 latency 16-bit", {47'd0, (n >= 1 && n <= 24)}, 48'd1);
    else if (w == 24)
      check("R5 latency 24-bit", {47'd0, (n >= 480 && n <= 544)}, 48'd1);
    else
      check("R5 latency 48-bit", {47'd0, (n >= 960 && n <= 1024)}, 48'd1);
    check(tag, m_data, ref_y(w));
    @(negedge clk);
    check("R4 valid one cycle", {47'd0, m_valid}, 48'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; mode = 2'b00; coef_we = 1'b0; coef_addr = '0;
    coef_data = '0; s_valid = 1'b0; s_data = '0;
    for (int k = 0; k < NT; k++) begin hist[k] = '0; coefs[k] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 m_valid after reset", {47'd0, m_valid}, 48'd0);
    check("R1 s_ready after reset", {47'd0, s_ready}, 48'd1);
    check("R1 m_data after reset", m_data, 48'd0);

    for (int k = 0; k < NT; k++) write_coef(k, rnd48());
    send("R1 empty history", rnd48());

    // R2/R3 16-bit random, junk in upper bits
    for (int i = 0; i < 30; i++) send("R2 R3 16-bit random", rnd48());

    // R7 out-of-range writes ignored, in-range take effect
    for (int a = NT; a < 32; a++) write_coef(a, rnd48());
    send("R7 out-of-range write ignored", rnd48());
    write_coef(0, rnd48());
    write_coef(NT - 1, rnd48());
    send("R7 in-range write applied", rnd48());

    // R8 most negative in 16-bit
    for (int k = 0; k < NT; k++) write_coef(k, {32'hA5A5_1234, 16'h8000});
    for (int i = 0; i < 22; i++) send("R8 16-bit min*min", {32'h5A5A_0F0F, 16'h8000});

    // R3 code 11 behaves as 16-bit
    for (int k = 0; k < NT; k++) write_coef(k, rnd48());
    set_mode(2'b11);
    send("R6 first result after change", rnd48());
    for (int i = 0; i < 6; i++) send("R3 code 11 as 16-bit", rnd48());

    // 24-bit
    set_mode(2'b01);
    send("R6 first result after change", rnd48());
    for (int i = 0; i < 14; i++) send("R2 R3 24-bit random", rnd48());
    for (int k = 0; k < NT; k++) write_coef(k, {24'h00FF00, 24'h800000});
    for (int i = 0; i < 3; i++) send("R8 24-bit min*min", {24'hFFFFFF, 24'h800000});

    // 48-bit
    for (int k = 0; k < NT; k++) write_coef(k, rnd48());
    set_mode(2'b10);
    send("R6 first result after change", rnd48());
    for (int i = 0; i < 10; i++) send("R2 48-bit random", rnd48());
    for (int k = 0; k < NT; k++) write_coef(k, 48'h8000_0000_0000);
    for (int i = 0; i < 3; i++) send("R8 48-bit min*min", 48'h8000_0000_0000);
    send("R2 48-bit mixed", 48'h7FFF_FFFF_FFFF);

    // back to 16-bit
    for (int k = 0; k < NT; k++) write_coef(k, rnd48());
    set_mode(2'b00);
    send("R6 first result after change", rnd48());
    for (int i = 0; i < 5; i++) send("R2 16-bit after return", rnd48());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule